// File: doc/BRIEF.md
# Line-Rate Subcarrier Control Receiver

This block sits between an upstream video decoder and the colour-subcarrier synthesizer of a video encoder. The decoder sends a serial control stream once per line, synchronous to the pixel clock. The block waits for the line to rest high for a minimum number of clocks. It takes the next falling edge as the start of a frame and treats that low level as a start symbol lasting one bit period. It then reads a fixed number of data bits, each held for a fixed number of clocks, and samples each bit on the last clock of its period.

When the last bit arrives, the block builds a new synthesizer frequency word and pulses an update strobe. The word is the received subcarrier increment placed above a constant block of low-order bits. In the same cycle the block updates the line-sequence flag, which marks a normal or an inverted line in PAL and has no meaning in NTSC. Also in that cycle it can pulse a reset request to the synthesizer. A new word arrives for every line, so the encoder follows the line-length variations of the source.

If a second start edge appears before a frame is complete, the partial frame is dropped and reception restarts. Dropping the enable has the same effect, and no start is recognised while the enable is low. The serial input is assumed to be already synchronous to the pixel clock.

Top module: `rtc_line_rx`

## Requirements
- R1: After reset, freq_word equals the increment field at zero above LOW_BITS, and freq_upd, line_seq and dds_rst are all low.
- R2: A frame starts only at a clock where en is high, rtc_in is low, and rtc_in was high on each of the IDLE_CLKS clocks just before. A fall after fewer high clocks starts nothing and produces no update.
- R3: Frame bit k (k = 0 first) is the level on rtc_in at the clock edge CLKS_PER_BIT*(k+2)-1 edges after the edge that first samples the start low. freq_upd is high for exactly one cycle, beginning CLKS_PER_BIT*(FRAME_BITS+1)-1 edges after that start edge (135 with the defaults).
- R4: At the update, freq_word[INC_W+LOW_W-1:LOW_W] takes frame bits 0..INC_W-1, with frame bit i in increment bit i. freq_word[LOW_W-1:0] always equals LOW_BITS. Frame bits outside the decoded positions have no effect.
- R5: At the update, line_seq takes frame bit SEQ_POS (64 by default).
- R6: dds_rst is high for one cycle, in the same cycle as freq_upd, exactly when frame bit RST_POS (65 by default) is 1. It is never high without freq_upd.
- R7: A start condition (as in R2) while a frame is in progress discards that frame with no update and no change to any output, then receives the new frame normally.
- R8: While en is low no frame starts, any frame in progress is discarded, and freq_upd stays low on the following cycle.
- R9: freq_word and line_seq change only in a cycle where freq_upd is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Receiver enable |
| rtc_in | input | 1 | Serial control line, idles high |
| freq_word | output | INC_W+LOW_W (32) | Synthesizer frequency word |
| freq_upd | output | 1 | One-cycle strobe when freq_word is new |
| line_seq | output | 1 | PAL line-sequence flag from the last frame |
| dds_rst | output | 1 | One-cycle synthesizer reset request |

## Verification
The bench builds the block with IDLE_CLKS = 6 and a non-zero LOW_BITS of 10'h2A5, and keeps the defaults for frame length and bit period. The non-zero constant makes any slip between the received increment and the fixed low bits show in the word. The longer idle threshold lets random frames carry runs of two high bits without being mistaken for a restart. It also puts both sides of the idle boundary, five and six high clocks, within a short directed sequence. With it, the bench can inject a true restart mid-frame, and can drop the enable in the middle of a frame.

// File: rtl/rtc_rx_pkg.sv
// Shared types for the line-rate subcarrier control receiver.
package rtc_rx_pkg;
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_t;
endpackage

// File: rtl/rtc_start_detect.sv
// Start-of-frame detector.
// Counts consecutive high clocks on the serial line, saturating at IDLE_CLKS.
// It flags a start when the line is low after at least IDLE_CLKS high clocks.
// Assumes the line is already synchronous to clk.
module rtc_start_detect #(
    parameter int IDLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line,
    output logic start
);
    localparam int HC_W = $clog2(IDLE_CLKS + 1);

    logic [HC_W-1:0] hi_cnt;

    // Track the length of the current high run, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!line) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HC_W'(IDLE_CLKS)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // A low sample after a long enough high run marks a frame start.
    always_comb begin
        start = en && !line && (hi_cnt == HC_W'(IDLE_CLKS));
    end
endmodule

// File: rtl/rtc_bit_timer.sv
// Bit-period timer.
// After a start it counts one start symbol and FRAME_BITS data symbols of
// CLKS_PER_BIT clocks each. It strobes on the last clock of every data symbol.
// A start always restarts the count. A low enable returns it to idle.
// Assumes CLKS_PER_BIT >= 2.
module rtc_bit_timer
    import rtc_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 2,
    parameter int FRAME_BITS   = 67
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    output logic take,
    output logic last
);
    localparam int PH_W  = $clog2(CLKS_PER_BIT);
    localparam int SYM_W = $clog2(FRAME_BITS + 1);
    localparam logic [PH_W-1:0]  PH_END  = PH_W'(CLKS_PER_BIT - 1);
    localparam logic [SYM_W-1:0] SYM_END = SYM_W'(FRAME_BITS);

    rx_state_t        state;
    logic [PH_W-1:0]  phase;
    logic [SYM_W-1:0] sym;
    logic             sample;

    // Sequence the start symbol and the data symbols of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state <= RX_IDLE;
            phase <= '0;
            sym   <= '0;
        end else if (start) begin
            state <= RX_RECV;
            phase <= PH_W'(1);
            sym   <= '0;
        end else if (state == RX_RECV) begin
            if (phase == PH_END) begin
                phase <= '0;
                if (sym == SYM_END) begin
                    state <= RX_IDLE;
                end else begin
                    sym <= sym + 1'b1;
                end
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Sample strobes: symbol 0 is the start symbol and carries no data.
    always_comb begin
        sample = en && !start && (state == RX_RECV) && (phase == PH_END);
        take   = sample && (sym != '0);
        last   = sample && (sym == SYM_END);
    end
endmodule

// File: rtl/rtc_frame_decode.sv
// Frame assembler and field decoder.
// Shifts in data bits with the earliest at bit 0. On the final bit it loads
// the frequency word, the line-sequence flag and the reset request, and it
// strobes the update. The final bit lies outside every decoded field.
module rtc_frame_decode #(
    parameter int FRAME_BITS = 67,
    parameter int INC_W      = 22,
    parameter int LOW_W      = 10,
    parameter int SEQ_POS    = 64,
    parameter int RST_POS    = 65,
    parameter logic [LOW_W-1:0] LOW_BITS = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line,
    input  logic                   take,
    input  logic                   last,
    output logic [INC_W+LOW_W-1:0] freq_word,
    output logic                   freq_upd,
    output logic                   line_seq,
    output logic                   dds_rst
);
    localparam int SW = FRAME_BITS - 1;

    logic [SW-1:0] sh;

    // Collect every data bit except the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (take && !last) begin
            sh <= {line, sh[SW-1:1]};
        end
    end

    // Publish the decoded fields when the frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_word <= {{INC_W{1'b0}}, LOW_BITS};
            freq_upd  <= 1'b0;
            line_seq  <= 1'b0;
            dds_rst   <= 1'b0;
        end else begin
            freq_upd <= last;
            dds_rst  <= last && sh[RST_POS];
            if (last) begin
                freq_word <= {sh[INC_W-1:0], LOW_BITS};
                line_seq  <= sh[SEQ_POS];
            end
        end
    end
endmodule

// File: rtl/rtc_line_rx.sv
// Line-rate subcarrier control receiver, top level.
// Detects frame starts on the serial line, times the bit periods and decodes
// each complete frame into a synthesizer frequency word, a line-sequence flag
// and a reset request. Assumes rtc_in is synchronous to clk.
module rtc_line_rx #(
    parameter int FRAME_BITS   = 67,
    parameter int CLKS_PER_BIT = 2,
    parameter int INC_W        = 22,
    parameter int LOW_W        = 10,
    parameter int SEQ_POS      = 64,
    parameter int RST_POS      = 65,
    parameter int IDLE_CLKS    = 4,
    parameter logic [LOW_W-1:0] LOW_BITS = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   rtc_in,
    output logic [INC_W+LOW_W-1:0] freq_word,
    output logic                   freq_upd,
    output logic                   line_seq,
    output logic                   dds_rst
);
    logic start;
    logic take;
    logic last;

    rtc_start_detect #(
        .IDLE_CLKS (IDLE_CLKS)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .line  (rtc_in),
        .start (start)
    );

    rtc_bit_timer #(
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .FRAME_BITS   (FRAME_BITS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .start (start),
        .take  (take),
        .last  (last)
    );

    rtc_frame_decode #(
        .FRAME_BITS (FRAME_BITS),
        .INC_W      (INC_W),
        .LOW_W      (LOW_W),
        .SEQ_POS    (SEQ_POS),
        .RST_POS    (RST_POS),
        .LOW_BITS   (LOW_BITS)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (rtc_in),
        .take      (take),
        .last      (last),
        .freq_word (freq_word),
        .freq_upd  (freq_upd),
        .line_seq  (line_seq),
        .dds_rst   (dds_rst)
    );
endmodule

// File: rtl/rtc_line_rx_chk.sv
// Port-level protocol checks for rtc_line_rx, attached with bind.
module rtc_line_rx_chk #(
    parameter int INC_W = 22,
    parameter int LOW_W = 10,
    parameter logic [LOW_W-1:0] LOW_BITS = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en,
    input logic [INC_W+LOW_W-1:0] freq_word,
    input logic                   freq_upd,
    input logic                   line_seq,
    input logic                   dds_rst
);
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) freq_upd |=> !freq_upd); // R3
    AST_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n) freq_word[LOW_W-1:0] == LOW_BITS); // R4
    AST_SEQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) !freq_upd |-> $stable(line_seq)); // R5
    AST_RST_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n) dds_rst |-> freq_upd); // R6
    AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !freq_upd); // R8
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !freq_upd |-> $stable(freq_word)); // R9
endmodule

bind rtc_line_rx rtc_line_rx_chk #(
    .INC_W    (INC_W),
    .LOW_W    (LOW_W),
    .LOW_BITS (LOW_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .freq_word (freq_word),
    .freq_upd  (freq_upd),
    .line_seq  (line_seq),
    .dds_rst   (dds_rst)
);

// File: tb/tb_rtc_line_rx.sv
`timescale 1ns/1ps
module tb_rtc_line_rx;
    localparam int FB   = 67;
    localparam int CPB  = 2;
    localparam int IW   = 22;
    localparam int LW   = 10;
    localparam int IDLE = 6;
    localparam int SEQP = 64;
    localparam int RSTP = 65;
    localparam int FW   = IW + LW;
    localparam logic [LW-1:0] LOWV = 10'h2A5;
    localparam int UPD_LAT = CPB * (FB + 1) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          rtc = 1'b1;
    logic [FW-1:0] freq_word;
    logic          freq_upd;
    logic          line_seq;
    logic          dds_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int upd_cnt = 0;
    int rst_cnt = 0;
    int upd_cyc = 0;
    logic [FW-1:0] upd_word = '0;
    logic upd_seq = 1'b0;
    logic upd_rst = 1'b0;

    rtc_line_rx #(
        .FRAME_BITS   (FB),
        .CLKS_PER_BIT (CPB),
        .INC_W        (IW),
        .LOW_W        (LW),
        .SEQ_POS      (SEQP),
        .RST_POS      (RSTP),
        .IDLE_CLKS    (IDLE),
        .LOW_BITS     (LOWV)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rtc_in    (rtc),
        .freq_word (freq_word),
        .freq_upd  (freq_upd),
        .line_seq  (line_seq),
        .dds_rst   (dds_rst)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record every strobe seen away from the active edge.
    always @(negedge clk) begin
        if (freq_upd) begin
            upd_cnt  <= upd_cnt + 1;
            upd_cyc  <= cyc;
            upd_word <= freq_word;
            upd_seq  <= line_seq;
            upd_rst  <= dds_rst;
        end
        if (dds_rst) rst_cnt <= rst_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] exp_word(input logic [FB-1:0] f);
        return {f[IW-1:0], LOWV};
    endfunction

    // Random frame with high runs of at most two bits (4 clocks < IDLE).
    function automatic logic [FB-1:0] rand_frame();
        logic [FB-1:0] f = '0;
        for (int k = 0; k < FB; k++) begin
            logic b = 1'($urandom & 1);
            if (k >= 2 && f[k-1] && f[k-2]) b = 1'b0;
            f[k] = b;
        end
        return f;
    endfunction

    task automatic drive(input logic v, input int n);
        repeat (n) begin
            @(negedge clk);
            rtc = v;
        end
    endtask

    task automatic send_head(input int pre, output int e0);
        drive(1'b1, pre);
        @(negedge clk);
        e0 = cyc + 1;
        rtc = 1'b0;
        drive(1'b0, CPB - 1);
    endtask

    task automatic send_bits(input logic [FB-1:0] f, input int from, input int upto);
        for (int k = from; k < upto; k++) drive(f[k], CPB);
    endtask

    task automatic send_frame(input logic [FB-1:0] f, input int pre, output int e0);
        send_head(pre, e0);
        send_bits(f, 0, FB);
        drive(1'b1, 8);
    endtask

    task automatic expect_update(input logic [FB-1:0] f, input int e0,
                                 input int n0, input int r0, input string tag);
        chk(upd_cnt == n0 + 1, "R3", {tag, " strobe count"}, 64'(upd_cnt), 64'(n0 + 1));
        chk(upd_cyc == e0 + UPD_LAT, "R3", {tag, " strobe cycle"}, 64'(upd_cyc), 64'(e0 + UPD_LAT));
        chk(upd_word == exp_word(f), "R4", {tag, " word"}, 64'(upd_word), 64'(exp_word(f)));
        chk(upd_seq == f[SEQP], "R5", {tag, " seq"}, 64'(upd_seq), 64'(f[SEQP]));
        chk(upd_rst == f[RSTP], "R6", {tag, " reset flag"}, 64'(upd_rst), 64'(f[RSTP]));
        chk(rst_cnt == r0 + int'(f[RSTP]), "R6", {tag, " reset pulses"}, 64'(rst_cnt), 64'(r0 + int'(f[RSTP])));
        chk(freq_word == exp_word(f), "R9", {tag, " word held"}, 64'(freq_word), 64'(exp_word(f)));
    endtask

    task automatic expect_none(input int n0, input logic [FW-1:0] w0, input logic s0,
                               input string req, input string tag);
        chk(upd_cnt == n0, req, {tag, " no strobe"}, 64'(upd_cnt), 64'(n0));
        chk(freq_word == w0, req, {tag, " word unchanged"}, 64'(freq_word), 64'(w0));
        chk(line_seq == s0, req, {tag, " seq unchanged"}, 64'(line_seq), 64'(s0));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int e0, n0, r0;
        logic [FB-1:0] f, g;
        logic [FW-1:0] w0;
        logic s0;
        void'($urandom(32'd20240611));

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(freq_word == {{IW{1'b0}}, LOWV}, "R1", "reset word", 64'(freq_word), 64'({{IW{1'b0}}, LOWV}));
        chk(!freq_upd, "R1", "reset strobe", 64'(freq_upd), 64'(0));
        chk(!line_seq, "R1", "reset seq", 64'(line_seq), 64'(0));
        chk(!dds_rst, "R1", "reset dds", 64'(dds_rst), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;

        // R4 R5 R6: directed patterns
        f = '0;
        n0 = upd_cnt; r0 = rst_cnt;
        send_frame(f, IDLE + 4, e0);
        expect_update(f, e0, n0, r0, "zeros");

        for (int k = 0; k < FB; k++) f[k] = (k % 3 != 2);
        f[RSTP] = 1'b1; f[SEQP] = 1'b1; f[RSTP + 1] = 1'b0; f[SEQP - 1] = 1'b0;
        n0 = upd_cnt; r0 = rst_cnt;
        send_frame(f, IDLE, e0);
        expect_update(f, e0, n0, r0, "dense");

        f = '0; f[RSTP] = 1'b1; f[FB-1] = 1'b1; f[30] = 1'b1; f[50] = 1'b1;
        n0 = upd_cnt; r0 = rst_cnt;
        send_frame(f, IDLE + 1, e0);
        expect_update(f, e0, n0, r0, "reset only");

        // R2 R8: fall while disabled, then a fall after IDLE-1 high clocks
        w0 = freq_word; s0 = line_seq; n0 = upd_cnt;
        @(negedge clk); en = 1'b0;
        drive(1'b0, 4);
        en = 1'b1;
        f = rand_frame();
        send_frame(f, IDLE - 1, e0);
        expect_none(n0, w0, s0, "R2", "short idle");

        // R2: exactly IDLE high clocks after a low stretch is accepted
        @(negedge clk); en = 1'b0;
        drive(1'b0, 4);
        en = 1'b1;
        f = rand_frame();
        n0 = upd_cnt; r0 = rst_cnt;
        send_frame(f, IDLE, e0);
        expect_update(f, e0, n0, r0, "R2 exact idle");

        // R8: enable dropped in the middle of a frame
        w0 = freq_word; s0 = line_seq; n0 = upd_cnt;
        g = rand_frame();
        send_head(IDLE, e0);
        send_bits(g, 0, 20);
        en = 1'b0;
        send_bits(g, 20, 22);
        en = 1'b1;
        send_bits(g, 22, FB);
        drive(1'b1, 8);
        expect_none(n0, w0, s0, "R8", "enable drop");

        // R7: restart mid-frame discards the partial frame
        g = rand_frame();
        f = rand_frame();
        f[SEQP] = ~line_seq;
        n0 = upd_cnt; r0 = rst_cnt;
        send_head(IDLE, e0);
        send_bits(g, 0, 33);
        send_frame(f, IDLE, e0);
        chk(upd_cnt == n0 + 1, "R7", "restart single strobe", 64'(upd_cnt), 64'(n0 + 1));
        expect_update(f, e0, n0, r0, "R7 restart");

        // R3 R4 R5 R6: random frames with varying idle gaps
        for (int i = 0; i < 12; i++) begin
            f = rand_frame();
            n0 = upd_cnt; r0 = rst_cnt;
            send_frame(f, IDLE + int'($urandom % 6), e0);
            expect_update(f, e0, n0, r0, "random");
        end

        summary();
        $finish;
    end
endmodule